// File: doc/BRIEF.md
# Input Capture with Noise Filter

This block timestamps edges on an external pin against a 16-bit free-running timer. The pin is brought into the clock domain by a two-flop synchronizer. An optional digital noise filter follows, and after it an edge detector whose polarity can be chosen. When a qualified edge arrives, the current timer value is copied into a capture register and a sticky capture flag is set. Software can use that flag as an interrupt request by setting an enable.

When the timer is configured so that its TOP value comes from the capture register, the pin must not change that register. While the TOP-is-capture indication is high, no capture takes place. The filter accepts a new level only after it has seen that level on four successive synchronized samples. This removes short glitches and adds a fixed latency of four clocks.

Two small state machines do the work. The filter machine has the states STEADY and CONFIRM:
- STEADY goes to CONFIRM when a sample differs from the filtered output.
- CONFIRM returns to STEADY, without changing the output, when a sample agrees with the output again.
- CONFIRM also returns to STEADY when the fourth differing sample in a row arrives. On that transition the output flips.

The level-tracking machine has the states LOW and HIGH:
- LOW goes to HIGH when the selected source is 1. That transition is a rising edge.
- HIGH goes to LOW when the source is 0. That transition is a falling edge.

An edge fires a capture only when its direction matches the edge select and TOP-is-capture is low.

Top module: `icap_unit`

## Requirements
- R1: After reset, cap_val_o is 0, cap_flag_o is 0 and irq_o is 0.
- R2: With filt_en_i = 0, a pin transition first sampled at clock edge n loads cap_val_o at edge n+2 with the count_i value present at that edge. cap_flag_o sets at the same edge, and neither changes at edge n+1.
- R3: With filt_en_i = 1, the same transition loads cap_val_o at edge n+6 with the count_i value present at that edge. This is four clocks later than in R2.
- R4: With filt_en_i = 1, a pin level held for fewer than four clocks causes no capture. A level held for four clocks is accepted.
- R5: rise_sel_i = 1 captures only on 0-to-1 pin transitions, and rise_sel_i = 0 captures only on 1-to-0 transitions. An edge of the other direction leaves cap_val_o and cap_flag_o unchanged.
- R6: While top_is_cap_i = 1, pin edges change neither cap_val_o nor cap_flag_o.
- R7: cap_flag_o stays 1 until flag_clr_i = 1 is sampled, and it reads 0 after that edge.
- R8: When flag_clr_i = 1 is sampled at the same edge as a capture, the capture wins and cap_flag_o stays 1.
- R9: A capture while cap_flag_o is already 1 overwrites cap_val_o with the new count.
- R10: irq_o is 1 exactly when cap_flag_o = 1 and irq_en_i = 1, and it follows irq_en_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw, asynchronous capture pin |
| count_i | input | 16 | Current timer count |
| filt_en_i | input | 1 | 1 = route the pin through the four-sample noise filter |
| rise_sel_i | input | 1 | 1 = capture on rising edges, 0 = capture on falling edges |
| top_is_cap_i | input | 1 | 1 = timer uses the capture register as TOP, so capture is blocked |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the capture flag |
| cap_val_o | output | 16 | Capture register |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures capture latency at the exact edge, for both the filtered and the unfiltered path. An extra or missing register stage would load the wrong count or set the flag one clock early or late.

It sends a three-clock pulse and then a four-clock pulse through the filter. A filter whose run counter is off by one would either pass the glitch or reject the valid pulse.

It also lines up a flag clear with a capture at the same edge. A design that gave the clear priority would drop an event.

Finally, it edges the pin while TOP-is-capture is set and with the wrong polarity selected. This exposes a design that still loads the register in those cases.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic {
        FLT_STEADY,
        FLT_CONFIRM
    } flt_state_t;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } lvl_state_t;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    output logic lvl_o
);
    localparam int RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    flt_state_t       state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             lvl_q, lvl_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            run_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            lvl_q   <= lvl_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (smp_i != lvl_q) begin
                    state_d = FLT_CONFIRM;
                    run_d   = RUN_W'(1);
                end
            end
            FLT_CONFIRM: begin
                if (smp_i == lvl_q) begin
                    state_d = FLT_STEADY;
                    run_d   = '0;
                end else if (run_q == RUN_LAST) begin
                    state_d = FLT_STEADY;
                    run_d   = '0;
                    lvl_d   = smp_i;
                end else begin
                    run_d = run_q + RUN_W'(1);
                end
            end
            default: state_d = FLT_STEADY;
        endcase
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic rise_sel_i,
    output logic trig_o
);
    lvl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        trig_o  = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (src_i) begin
                    state_d = LVL_HIGH;
                    trig_o  = rise_sel_i;
                end
            end
            LVL_HIGH: begin
                if (!src_i) begin
                    state_d = LVL_LOW;
                    trig_o  = !rise_sel_i;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_RUN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             filt_en_i,
    input  logic             rise_sel_i,
    input  logic             top_is_cap_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_flag_o,
    output logic             irq_o
);
    logic pin_s;
    logic pin_f;
    logic edge_src;
    logic edge_trig;
    logic cap_fire;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    icap_filter #(.RUN_LEN(FILT_RUN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_i (pin_s),
        .lvl_o (pin_f)
    );

    assign edge_src = filt_en_i ? pin_f : pin_s;

    icap_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (edge_src),
        .rise_sel_i (rise_sel_i),
        .trig_o     (edge_trig)
    );

    // Capture is blocked while the register serves as TOP
    assign cap_fire = edge_trig && !top_is_cap_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val_o  <= '0;
            cap_flag_o <= 1'b0;
        end else begin
            if (cap_fire) begin
                cap_val_o  <= count_i;
                cap_flag_o <= 1'b1;
            end else if (flag_clr_i) begin
                cap_flag_o <= 1'b0;
            end
        end
    end

    assign irq_o = cap_flag_o && irq_en_i;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_i,
    input logic             top_is_cap_i,
    input logic             irq_en_i,
    input logic             flag_clr_i,
    input logic             cap_fire,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             cap_flag_o,
    input logic             irq_o
);
    // R2: a capture loads the count and sets the flag
    p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cap_flag_o && cap_val_o == $past(count_i)));

    // R6: the register is untouched while it serves as TOP
    p_top_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        top_is_cap_i |=> $stable(cap_val_o));

    p_top_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        top_is_cap_i |=> !$rose(cap_flag_o));

    // R7: sticky flag, cleared by request
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cap_fire) |=> !cap_flag_o);

    // R8: capture beats a simultaneous clear
    p_capture_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && cap_fire) |=> cap_flag_o);

    // R10: no request without the enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_i      (count_i),
    .top_is_cap_i (top_is_cap_i),
    .irq_en_i     (irq_en_i),
    .flag_clr_i   (flag_clr_i),
    .cap_fire     (cap_fire),
    .cap_val_o    (cap_val_o),
    .cap_flag_o   (cap_flag_o),
    .irq_o        (irq_o)
);

// File: tb/icap_unit_test.sv
`timescale 1ns/1ps
module icap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_i = 1'b0;
    logic [15:0] count_i = 16'd0;
    logic        filt_en_i = 1'b0;
    logic        rise_sel_i = 1'b1;
    logic        top_is_cap_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] cap_val_o;
    logic        cap_flag_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Free-running timer stand-in
    always @(posedge clk) count_i <= count_i + 16'd1;

    icap_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_i),
        .count_i      (count_i),
        .filt_en_i    (filt_en_i),
        .rise_sel_i   (rise_sel_i),
        .top_is_cap_i (top_is_cap_i),
        .irq_en_i     (irq_en_i),
        .flag_clr_i   (flag_clr_i),
        .cap_val_o    (cap_val_o),
        .cap_flag_o   (cap_flag_o),
        .irq_o        (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr_i = 1'b1;
        @(negedge clk) flag_clr_i = 1'b0;
    endtask

    task automatic settle(input logic lvl);
        @(negedge clk) pin_i = lvl;
        wait_cycles(12);
    endtask

    // Drive a pin level and check the capture appears exactly lat edges later
    task automatic edge_expect(input logic lvl, input int lat, input string req);
        logic [15:0] base;
        logic [15:0] prior;
        @(negedge clk);
        prior = cap_val_o;
        pin_i = lvl;
        base  = count_i;
        wait_cycles(lat);
        check({req, " value not yet loaded"}, cap_val_o, prior);
        @(negedge clk);
        check({req, " flag set"}, cap_flag_o, 1);
        check({req, " captured count"}, cap_val_o, base + 16'(lat));
    endtask

    task automatic t_reset();
        check("R1 cap_val reset", cap_val_o, 0);
        check("R1 flag reset", cap_flag_o, 0);
        check("R1 irq reset", irq_o, 0);
    endtask

    task automatic t_rise_unfiltered();
        filt_en_i = 1'b0;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        edge_expect(1'b1, 2, "R2 unfiltered rise");
    endtask

    task automatic t_polarity();
        logic [15:0] held;
        filt_en_i = 1'b0;
        rise_sel_i = 1'b1;
        settle(1'b1);
        clear_flag();
        held = cap_val_o;
        settle(1'b0);
        check("R5 falling ignored when rise selected: flag", cap_flag_o, 0);
        check("R5 falling ignored when rise selected: value", cap_val_o, held);
        rise_sel_i = 1'b0;
        settle(1'b1);
        check("R5 rising ignored when fall selected", cap_flag_o, 0);
        edge_expect(1'b0, 2, "R5 falling capture");
        rise_sel_i = 1'b1;
    endtask

    task automatic t_filtered();
        filt_en_i = 1'b1;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        edge_expect(1'b1, 6, "R3 filtered rise");
        settle(1'b1);
        filt_en_i = 1'b0;
    endtask

    task automatic t_glitch();
        logic [15:0] held;
        filt_en_i = 1'b1;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        held = cap_val_o;
        @(negedge clk) pin_i = 1'b1;
        wait_cycles(3);
        pin_i = 1'b0;
        wait_cycles(14);
        check("R4 three-clock glitch rejected: flag", cap_flag_o, 0);
        check("R4 three-clock glitch rejected: value", cap_val_o, held);
        @(negedge clk) pin_i = 1'b1;
        wait_cycles(4);
        pin_i = 1'b0;
        wait_cycles(14);
        check("R4 four-clock pulse accepted", cap_flag_o, 1);
        filt_en_i = 1'b0;
        settle(1'b0);
    endtask

    task automatic t_top_block();
        logic [15:0] held;
        filt_en_i = 1'b0;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        held = cap_val_o;
        top_is_cap_i = 1'b1;
        settle(1'b1);
        check("R6 no flag while capture is TOP", cap_flag_o, 0);
        check("R6 value kept while capture is TOP", cap_val_o, held);
        settle(1'b0);
        top_is_cap_i = 1'b0;
    endtask

    task automatic t_sticky_irq();
        filt_en_i = 1'b0;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        edge_expect(1'b1, 2, "R7 setup capture");
        irq_en_i = 1'b0;
        wait_cycles(10);
        check("R7 flag stays set", cap_flag_o, 1);
        check("R10 irq off when disabled", irq_o, 0);
        irq_en_i = 1'b1;
        #0.5;
        check("R10 irq follows enable", irq_o, 1);
        @(negedge clk) flag_clr_i = 1'b1;
        @(negedge clk) flag_clr_i = 1'b0;
        check("R7 flag cleared", cap_flag_o, 0);
        check("R10 irq drops with flag", irq_o, 0);
        irq_en_i = 1'b0;
    endtask

    task automatic t_overwrite();
        filt_en_i = 1'b0;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        edge_expect(1'b1, 2, "R9 first capture");
        settle(1'b0);
        check("R9 flag still set before second", cap_flag_o, 1);
        edge_expect(1'b1, 2, "R9 overwrite");
    endtask

    task automatic t_clear_race();
        logic [15:0] base;
        filt_en_i = 1'b0;
        rise_sel_i = 1'b1;
        settle(1'b0);
        clear_flag();
        @(negedge clk);
        pin_i = 1'b1;
        base  = count_i;
        wait_cycles(2);
        flag_clr_i = 1'b1;
        @(negedge clk) flag_clr_i = 1'b0;
        check("R8 capture wins over clear", cap_flag_o, 1);
        check("R8 value loaded", cap_val_o, base + 16'd2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_unfiltered();
        t_polarity();
        t_filtered();
        t_glitch();
        t_top_block();
        t_sticky_irq();
        t_overwrite();
        t_clear_race();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule